// File: doc/BRIEF.md
# Linear Charger Control Sequencer

This block is the digital supervisor of a linear battery charger. It watches a set of comparator flags, already deglitched and synchronous to the clock: input power present, battery above its low-voltage threshold, charge current under the termination level, battery under the recharge level, voltage-regulation mode, current-limiting loop active and junction over-temperature. From these it chooses among five states (off, precharge, fast charge, done and fault). It drives the charge-enable and precharge-select controls of the analog stage.

Every time measurement uses a shared prescaled tick, a one-cycle pulse. Three decisions must be qualified: falling back to precharge, declaring the charge done, and starting a recharge. Each one needs its condition to stay true for a programmed number of ticks, and the count starts again whenever the condition drops. A safety timer limits time spent in precharge and fast charge. The timer stops counting while the current-limiting loop is active, but this paused time is capped at twice the timeout. A timeout latches a fault. The block has no data stream, so every pin is a plain level control or status signal.

Top module: `chg_seq`

## Requirements
- R1: Reset places the block in off with every output low. Whenever the enable or input power is low, the state is off from the next clock on.
- R2: The state code on `state_o` is 0 = off, 1 = precharge, 2 = fast charge, 3 = done, 4 = fault. With enable and power high and no over-temperature, off goes to precharge on the next cycle. Precharge goes to fast charge on the cycle after the battery-above-threshold flag is seen high.
- R3: In fast charge, a low battery flag held for QUAL_TICKS consecutive ticks returns the block to precharge. A shorter dropout restarts the count and has no effect.
- R4: In fast charge, the termination flag held together with voltage-regulation mode for QUAL_TICKS ticks moves the block to done. The termination flag alone, outside voltage-regulation mode, never does.
- R5: In done, the recharge flag held for QUAL_TICKS ticks starts a new cycle in precharge. A shorter pulse leaves the block in done.
- R6: Once the safety timer has counted FAST_TO_TICKS ticks in fast charge, the block enters fault on the following cycle. In precharge the limit is FAST_TO_TICKS / PRE_DIV ticks. The timer restarts on every state change.
- R7: A tick that arrives while the current-limiting loop is active does not advance the safety timer. Such paused ticks are capped at twice the active limit; once the cap is reached the timer counts again.
- R8: Fault holds while enable and power stay high, whatever the other flags do. It clears to off only when power is removed or enable is dropped.
- R9: Over-temperature forces any state except fault to off on the next cycle. Charging resumes through precharge once the flag clears.
- R10: `loop_flag_o` rises only after the loop-active flag has been high for LOOP_TICKS consecutive ticks. It falls on the cycle after the loop-active flag drops.
- R11: `chg_en_o` is high exactly in precharge and fast charge. `pre_sel_o` is high exactly in precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled time base, one-cycle pulse |
| chg_enable_i | input | 1 | Charge function enable from the register file |
| pwr_ok_i | input | 1 | Input power present |
| bat_ok_i | input | 1 | Battery above the low-voltage threshold |
| iterm_low_i | input | 1 | Charge current below termination level |
| vreg_mode_i | input | 1 | Charger is in voltage-regulation mode |
| bat_rch_i | input | 1 | Battery below the recharge level |
| loop_act_i | input | 1 | Input-limit or thermal regulation loop active |
| over_temp_i | input | 1 | Junction over-temperature |
| chg_en_o | output | 1 | Charge enable to the analog stage |
| pre_sel_o | output | 1 | Precharge current select |
| state_o | output | 3 | Current state code |
| loop_flag_o | output | 1 | Qualified loop-active status |

## Verification
The assertions assume four things: every flag is synchronous and held steady across the clock edge, `tick_i` is never high on two adjacent cycles, PRE_DIV is no larger than FAST_TO_TICKS, and the qualified-decision lengths are at least one tick. The bench changes inputs only on the falling clock edge. It produces ticks either as isolated one-cycle pulses in the directed cases or as random single-cycle pulses gated by the previous cycle. Random toggling of the flags is biased so that enable and power stay high most of the time, which lets qualification windows and safety timeouts actually complete.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } chg_state_e;

  // indices of the qualified conditions
  localparam int unsigned QI_LOW  = 0;
  localparam int unsigned QI_TERM = 1;
  localparam int unsigned QI_RCH  = 2;
  localparam int unsigned QI_LOOP = 3;
  localparam int unsigned NQ      = 4;
endpackage

// File: rtl/chg_qual.sv
module chg_qual #(
  parameter int unsigned LEN = 3,
  parameter int unsigned CW  = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!cond)                   cnt <= '0;
    else if (tick && cnt != CW'(LEN)) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == CW'(LEN));

  // R3 R4 R5 R10: a qualified level needs its condition present at the edge before
  hit_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(cond));

  // R3 R4 R5 R10: qualification completes only on a tick
  hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(tick));
endmodule

// File: rtl/chg_safety_tmr.sv
module chg_safety_tmr #(
  parameter int unsigned FAST_TO = 20,
  parameter int unsigned PRE_DIV = 10,
  parameter int unsigned TW      = $clog2(3 * FAST_TO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic in_pre,
  input  logic in_fast,
  input  logic pause_req,
  output logic expired
);
  localparam int unsigned PRE_TO = FAST_TO / PRE_DIV;

  logic [TW-1:0] lim;
  logic [TW-1:0] run;
  logic [TW-1:0] ext;
  logic          active;
  logic          pausing;

  assign active  = in_pre | in_fast;
  assign lim     = in_pre ? TW'(PRE_TO) : (in_fast ? TW'(FAST_TO) : '0);
  assign pausing = pause_req && ({1'b0, ext} < {lim, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !active) begin
      run <= '0;
      ext <= '0;
    end else if (tick) begin
      if (pausing)        ext <= ext + 1'b1;
      else if (run < lim) run <= run + 1'b1;
    end
  end

  assign expired = active && (run >= lim);

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && tick && pause_req && ({1'b0, ext} < {lim, 1'b0})) |=> $stable(run));

  // R6
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(expired) && $past(active)) |-> $past(tick));
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pwr_ok,
  input  logic       ot,
  input  logic       bat_ok,
  input  logic       low_q,
  input  logic       term_q,
  input  logic       rch_q,
  input  logic       expired,
  output chg_state_e st,
  output logic       tmr_clr
);
  chg_state_e nxt;

  always_comb begin
    nxt = st;
    if (!en || !pwr_ok) begin
      nxt = ST_OFF;
    end else if (st == ST_FAULT) begin
      nxt = ST_FAULT;
    end else if (ot) begin
      nxt = ST_OFF;
    end else begin
      case (st)
        ST_OFF:  nxt = ST_PRE;
        ST_PRE:  nxt = expired ? ST_FAULT : (bat_ok ? ST_FAST : ST_PRE);
        ST_FAST: begin
          if (expired)     nxt = ST_FAULT;
          else if (low_q)  nxt = ST_PRE;
          else if (term_q) nxt = ST_DONE;
          else             nxt = ST_FAST;
        end
        ST_DONE: nxt = rch_q ? ST_PRE : ST_DONE;
        default: nxt = ST_OFF;
      endcase
    end
  end

  assign tmr_clr = (nxt != st);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end

  // R1
  off_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && pwr_ok) |=> st == ST_OFF);

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && en && pwr_ok) |=> st == ST_FAULT);

  // R9
  ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_ok && ot && st != ST_FAULT) |=> st == ST_OFF);

  // R6
  expire_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_ok && !ot && expired && (st == ST_PRE || st == ST_FAST)) |=> st == ST_FAULT);
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int unsigned QUAL_TICKS    = 45,
  parameter int unsigned LOOP_TICKS    = 1,
  parameter int unsigned FAST_TO_TICKS = 36000000,
  parameter int unsigned PRE_DIV       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       chg_enable_i,
  input  logic       pwr_ok_i,
  input  logic       bat_ok_i,
  input  logic       iterm_low_i,
  input  logic       vreg_mode_i,
  input  logic       bat_rch_i,
  input  logic       loop_act_i,
  input  logic       over_temp_i,
  output logic       chg_en_o,
  output logic       pre_sel_o,
  output logic [2:0] state_o,
  output logic       loop_flag_o
);
  chg_state_e    st;
  logic          tmr_clr;
  logic          expired;
  logic [NQ-1:0] qcond;
  logic [NQ-1:0] qhit;

  assign qcond[QI_LOW]  = (st == ST_FAST) && !bat_ok_i;
  assign qcond[QI_TERM] = (st == ST_FAST) && iterm_low_i && vreg_mode_i;
  assign qcond[QI_RCH]  = (st == ST_DONE) && bat_rch_i;
  assign qcond[QI_LOOP] = loop_act_i;

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    localparam int unsigned LEN = (g == QI_LOOP) ? LOOP_TICKS : QUAL_TICKS;
    chg_qual #(.LEN(LEN)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_i),
      .cond (qcond[g]),
      .hit  (qhit[g])
    );
  end

  chg_safety_tmr #(.FAST_TO(FAST_TO_TICKS), .PRE_DIV(PRE_DIV)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .clr      (tmr_clr),
    .in_pre   (st == ST_PRE),
    .in_fast  (st == ST_FAST),
    .pause_req(loop_act_i),
    .expired  (expired)
  );

  chg_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (chg_enable_i),
    .pwr_ok (pwr_ok_i),
    .ot     (over_temp_i),
    .bat_ok (bat_ok_i),
    .low_q  (qhit[QI_LOW]),
    .term_q (qhit[QI_TERM]),
    .rch_q  (qhit[QI_RCH]),
    .expired(expired),
    .st     (st),
    .tmr_clr(tmr_clr)
  );

  assign chg_en_o    = (st == ST_PRE) || (st == ST_FAST);
  assign pre_sel_o   = (st == ST_PRE);
  assign state_o     = st;
  assign loop_flag_o = qhit[QI_LOOP];

  // R11
  pre_implies_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_sel_o |-> chg_en_o);
endmodule

// File: tb/tb_chg_seq.sv
`timescale 1ns/1ps
module tb_chg_seq;
  localparam int QUAL = 3;
  localparam int LOOPT = 2;
  localparam int FTO = 20;
  localparam int PDIV = 10;
  localparam int PTO = FTO / PDIV;

  logic clk = 0, rst_n = 0, tick = 0;
  logic en = 0, pwr = 0, bat_ok = 0, iterm = 0, vreg = 0, rch = 0, loopa = 0, ot = 0;
  logic chg_en, pre_sel, loop_flag;
  logic [2:0] st;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chg_seq #(.QUAL_TICKS(QUAL), .LOOP_TICKS(LOOPT), .FAST_TO_TICKS(FTO), .PRE_DIV(PDIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .chg_enable_i(en), .pwr_ok_i(pwr),
    .bat_ok_i(bat_ok), .iterm_low_i(iterm), .vreg_mode_i(vreg), .bat_rch_i(rch),
    .loop_act_i(loopa), .over_temp_i(ot), .chg_en_o(chg_en), .pre_sel_o(pre_sel),
    .state_o(st), .loop_flag_o(loop_flag));

  // expected behaviour from the requirements, advanced on each rising edge
  int m_st = 0, m_run = 0, m_ext = 0;
  int m_c[4];

  function automatic int qlen(int k);
    return (k == 3) ? LOOPT : QUAL;
  endfunction

  function automatic int next_state(int s, bit e, bit p, bit o, bit b, bit lq, bit tq, bit rq, bit ex);
    if (!e || !p) return 0;
    if (s == 4) return 4;
    if (o) return 0;
    case (s)
      0: return 1;
      1: return ex ? 4 : (b ? 2 : 1);
      2: return ex ? 4 : (lq ? 1 : (tq ? 3 : 2));
      3: return rq ? 1 : 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    int lim, nx;
    bit act, ex;
    bit cnd[4];
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_ext = 0;
      for (int k = 0; k < 4; k++) m_c[k] = 0;
    end else begin
      act = (m_st == 1) || (m_st == 2);
      lim = (m_st == 1) ? PTO : ((m_st == 2) ? FTO : 0);
      ex = act && (m_run >= lim);
      nx = next_state(m_st, en, pwr, ot, bat_ok, m_c[0] == QUAL, m_c[1] == QUAL, m_c[2] == QUAL, ex);
      cnd[0] = (m_st == 2) && !bat_ok;
      cnd[1] = (m_st == 2) && iterm && vreg;
      cnd[2] = (m_st == 3) && rch;
      cnd[3] = loopa;
      for (int k = 0; k < 4; k++) begin
        if (!cnd[k]) m_c[k] = 0;
        else if (tick && m_c[k] != qlen(k)) m_c[k]++;
      end
      if (nx != m_st || !act) begin
        m_run = 0; m_ext = 0;
      end else if (tick) begin
        if (loopa && m_ext < 2 * lim) m_ext++;
        else if (m_run < lim) m_run++;
      end
      m_st = nx;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk);
      tick = 0; @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 reset state", st, 0);
    chk("R1 reset chg_en", chg_en, 0);
    chk("R11 reset pre_sel", pre_sel, 0);
    chk("R10 reset loop flag", loop_flag, 0);

    // R2 off -> precharge
    en = 1; pwr = 1; bat_ok = 0;
    cyc(1);
    chk("R2 enter precharge", st, 1);
    chk("R11 chg_en in precharge", chg_en, 1);
    chk("R11 pre_sel in precharge", pre_sel, 1);

    // R6 precharge timeout
    ticks(PTO);
    chk("R6 precharge timeout", st, 4);
    chk("R11 chg_en in fault", chg_en, 0);

    // R8 fault latched
    bat_ok = 1; ot = 1; cyc(3); ot = 0; ticks(3);
    chk("R8 fault holds", st, 4);
    en = 0; cyc(1);
    chk("R8 enable clears fault", st, 0);
    en = 1; cyc(1);
    chk("R2 precharge again", st, 1);
    cyc(1);
    chk("R2 precharge to fast", st, 2);
    chk("R11 pre_sel low in fast", pre_sel, 0);

    // R3 low battery qualification
    bat_ok = 0; ticks(QUAL - 1); bat_ok = 1; cyc(1);
    chk("R3 short dropout ignored", st, 2);
    bat_ok = 0; ticks(QUAL);
    chk("R3 qualified low battery", st, 1);
    bat_ok = 1; cyc(1);
    chk("R2 back to fast", st, 2);

    // R4 termination needs voltage-regulation mode
    iterm = 1; vreg = 0; ticks(QUAL + 2);
    chk("R4 no done outside vreg mode", st, 2);
    vreg = 1; ticks(QUAL);
    chk("R4 done", st, 3);
    chk("R11 chg_en off in done", chg_en, 0);
    iterm = 0; vreg = 0;

    // R5 recharge qualification
    rch = 1; ticks(QUAL - 1); rch = 0; cyc(1);
    chk("R5 short recharge ignored", st, 3);
    rch = 1; ticks(QUAL);
    chk("R5 recharge starts precharge", st, 1);
    rch = 0; cyc(1);
    chk("R5 recharge reaches fast", st, 2);

    // R7 pause with cap, R10 loop flag
    loopa = 1; ticks(LOOPT - 1);
    chk("R10 loop flag not yet", loop_flag, 0);
    ticks(1);
    chk("R10 loop flag set", loop_flag, 1);
    ticks(3 * FTO - 1 - LOOPT);
    chk("R7 still fast before capped timeout", st, 2);
    ticks(1);
    chk("R7 fault after cap plus timeout", st, 4);
    loopa = 0; cyc(1);
    chk("R10 loop flag drops", loop_flag, 0);
    pwr = 0; cyc(1);
    chk("R8 power removal clears fault", st, 0);

    // R6 fast timeout without loop
    pwr = 1; cyc(2);
    chk("R2 fast again", st, 2);
    ticks(FTO - 1);
    chk("R6 fast before timeout", st, 2);
    ticks(1);
    chk("R6 fast timeout", st, 4);
    pwr = 0; cyc(1); pwr = 1; cyc(2);

    // R9 over-temperature
    ot = 1; cyc(1);
    chk("R9 over-temp off", st, 0);
    cyc(3);
    chk("R9 held off", st, 0);
    ot = 0; cyc(1);
    chk("R9 resume precharge", st, 1);
    cyc(1);
    chk("R9 resume fast", st, 2);

    // R1 power removal in fast
    pwr = 0; cyc(1);
    chk("R1 power loss off", st, 0);
    pwr = 1;

    // R10 interrupted loop
    loopa = 1; ticks(LOOPT - 1); loopa = 0; cyc(1); loopa = 1; ticks(LOOPT - 1);
    chk("R10 interrupted loop", loop_flag, 0);
    loopa = 0;

    // random phase compared with the requirement model
    for (int i = 0; i < 6000; i++) begin
      tick = tick ? 1'b0 : 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 2) en = ~en;
      if ($urandom_range(0, 99) < 2) pwr = ~pwr;
      if (!en && $urandom_range(0, 9) < 3) en = 1;
      if (!pwr && $urandom_range(0, 9) < 3) pwr = 1;
      if ($urandom_range(0, 99) < 5) bat_ok = ~bat_ok;
      if ($urandom_range(0, 99) < 10) iterm = ~iterm;
      if ($urandom_range(0, 99) < 5) vreg = ~vreg;
      if ($urandom_range(0, 99) < 10) rch = ~rch;
      if ($urandom_range(0, 99) < 8) loopa = ~loopa;
      if ($urandom_range(0, 199) < 1) ot = 1;
      else if (ot && $urandom_range(0, 9) < 3) ot = 0;
      @(negedge clk);
      chk("R2 R3 R4 R5 R6 R7 R8 R9 random state", st, m_st);
      chk("R11 random chg_en", chg_en, int'(m_st == 1 || m_st == 2));
      chk("R11 random pre_sel", pre_sel, int'(m_st == 1));
      chk("R10 random loop flag", loop_flag, int'(m_c[3] == LOOPT));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule